// File: doc/BRIEF.md
# PECI Host Controller Register Interface

This block is the processor-facing register file of a PECI host controller. A processor programs a transaction over a byte-wide register bus: the target address, the transmit and receive byte counts, the first transmit byte, further transmit bytes in a byte buffer, the pull-down strength and the bit-rate divisor. It then writes the start bit. The block latches the transaction settings into engine-facing copies and pulses a start strobe to an external transaction engine. It keeps the start bit set as a busy flag until the engine reports completion. When the engine finishes, the block raises a sticky done flag, together with any CRC or abort error the engine reports. It can also raise an interrupt.

The byte buffer is shared between the processor and the engine. The processor writes the outgoing bytes before starting a transaction and reads the received bytes after done. A free-running divider derives the negotiation bit tick from the programmed divisor.

The sequencing is a three-state machine:
- IDLE: no transaction is running.
- LAUNCH: one cycle, in which the start strobe is driven.
- WAIT: the engine is running.

It has three transitions:
- START: IDLE to LAUNCH, on a write of 1 to the start bit.
- ISSUE: LAUNCH to WAIT, unconditionally.
- FINISH: WAIT to IDLE, on the engine's done input.

Top module: `peci_host_regs`

## Requirements
- R1: After reset every register reads zero except the divisor (offset 0x2C), which reads 15. The byte buffer reads zero, and `irq` and `eng_start` are low.
- R2: Writing a status byte (offset 0x00) with bit 0 set while idle (START) makes status bit 0 read 1 from the next cycle. It also drives `eng_start` high for exactly the one cycle after the write (LAUNCH).
- R3: An `eng_done` pulse during WAIT (FINISH) clears status bit 0 and sets the done flag (bit 1) from the next cycle, whether or not an error is reported. `eng_crc_err` sampled with it sets bit 3, and `eng_abort_err` sets bit 4. Status bits 2, 5 and 7 always read 0.
- R4: The done, CRC and abort flags are sticky. Writing 1 to bit 1, 3 or 4 clears that flag. Writing 0 leaves it unchanged. Bit 6 is the interrupt enable and is plainly written.
- R5: A write of 1 to bit 0 while busy produces no further `eng_start` pulse.
- R6: Writes to the target address (0x08), command (0x0C), lengths or control 2 while busy update the readback value but not the engine-side outputs, which hold the values latched at START.
- R7: Receive length (0x04) and transmit length (0x1C) keep bits 6:0. Bit 7 reads 0.
- R8: Control 2 (0x10) keeps the pull-down strength in bits 7:6 and reads 0 in bits 5:0. A write whose bits 7:6 equal 3 is ignored.
- R9: The divisor register (0x2C) keeps N in bits 4:0. A write whose bits 4:0 fall outside 7..31 is ignored.
- R10: `bit_tick` pulses for one cycle every 4*(N+1) clock cycles.
- R11: `irq` is high exactly while both the done flag and the interrupt enable are set.
- R12: Buffer entry n sits at byte address 0x100 + 4*n. Bytes at 0x100 + 4*n + 1..3 read 0 and ignore writes. Processor writes to the buffer are ignored while busy. An engine write is readable by the processor from the next cycle, and `eng_buf_rdata` shows the entry at `eng_buf_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 10 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Done interrupt |
| eng_start | output | 1 | One-cycle start strobe to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_crc_err | input | 1 | CRC error, valid with `eng_done` |
| eng_abort_err | input | 1 | Abort error, valid with `eng_done` |
| eng_tgt_addr | output | 8 | Latched target address |
| eng_cmd | output | 8 | Latched first transmit byte |
| eng_wr_len | output | 7 | Latched transmit length |
| eng_rd_len | output | 7 | Latched receive length |
| eng_pulldown | output | 2 | Latched pull-down strength |
| eng_buf_idx | input | 6 | Engine buffer entry index |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Buffer entry at `eng_buf_idx` |
| bit_tick | output | 1 | Negotiation bit-clock tick |

## Verification
Register reads are combinational, so a bus write becomes visible from the first falling edge after the edge that captures it. The bench samples every readback, `irq` and the engine outputs at falling edges. `eng_start` is due exactly one cycle after the start write and must be gone one cycle later. Status after FINISH is read on the next falling edge after the edge that sees `eng_done`. The bit tick is measured in falling-edge counts between two consecutive pulses, always after one pulse has passed since the divisor changed.

// File: rtl/peci_host_pkg.sv
package peci_host_pkg;

    // Register byte offsets (software visible)
    localparam int unsigned OFS_STATUS  = 32'h000;
    localparam int unsigned OFS_RD_LEN  = 32'h004;
    localparam int unsigned OFS_TGT     = 32'h008;
    localparam int unsigned OFS_CMD     = 32'h00C;
    localparam int unsigned OFS_CTL2    = 32'h010;
    localparam int unsigned OFS_WR_LEN  = 32'h01C;
    localparam int unsigned OFS_DIV     = 32'h02C;
    localparam int unsigned OFS_BUF     = 32'h100;

    // Status bit positions
    localparam int unsigned SB_BUSY  = 0;
    localparam int unsigned SB_DONE  = 1;
    localparam int unsigned SB_CRC   = 3;
    localparam int unsigned SB_ABORT = 4;
    localparam int unsigned SB_IE    = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/peci_busy_fsm.sv
module peci_busy_fsm
    import peci_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic eng_done,
    output logic busy,
    output logic accept,
    output logic eng_start,
    output logic finish
);

    xfer_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (eng_done) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        accept    = (state_q == ST_IDLE) && go;
        eng_start = (state_q == ST_LAUNCH);
        finish    = (state_q == ST_WAIT) && eng_done;
    end

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && eng_start));
    assert_finish_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy);
    assert_restart_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && go) |=> !eng_start);

endmodule

// File: rtl/peci_bitclk_div.sv
module peci_bitclk_div #(
    parameter int unsigned DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam int unsigned CNT_W = DIV_W + 3;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] term;

    always_comb begin
        limit = (CNT_W'(div) + CNT_W'(1)) << 2;
        term  = limit - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= term) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            tick  <= 1'b0;
        end
    end

    assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/peci_byte_buf.sv
module peci_byte_buf #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned W     = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [W-1:0]     host_wdata,
    output logic [W-1:0]     host_rdata,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [W-1:0]     eng_wdata,
    output logic [W-1:0]     eng_rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (host_we && !(eng_we && eng_idx == host_idx)) mem[host_idx] <= host_wdata;
            if (eng_we) mem[eng_idx] <= eng_wdata;
        end
    end

    assign host_rdata = mem[host_idx];
    assign eng_rdata  = mem[eng_idx];

    assert_eng_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |=> (mem[$past(eng_idx)] == $past(eng_wdata)));

endmodule

// File: rtl/peci_host_regs.sv
module peci_host_regs
    import peci_host_pkg::*;
#(
    parameter int unsigned BUS_AW    = 10,
    parameter int unsigned BUF_DEPTH = 64,
    parameter int unsigned LEN_W     = 7,
    parameter int unsigned DIV_W     = 5,
    parameter int unsigned DIV_MIN   = 7,
    parameter int unsigned DIV_MAX   = 31,
    parameter int unsigned DIV_RST   = 15,
    parameter int unsigned PD_MAX    = 2,
    localparam int unsigned IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              eng_start,
    input  logic              eng_done,
    input  logic              eng_crc_err,
    input  logic              eng_abort_err,
    output logic [7:0]        eng_tgt_addr,
    output logic [7:0]        eng_cmd,
    output logic [LEN_W-1:0]  eng_wr_len,
    output logic [LEN_W-1:0]  eng_rd_len,
    output logic [1:0]        eng_pulldown,
    input  logic [IDX_W-1:0]  eng_buf_idx,
    input  logic              eng_buf_we,
    input  logic [7:0]        eng_buf_wdata,
    output logic [7:0]        eng_buf_rdata,
    output logic              bit_tick
);

    localparam logic [BUS_AW-1:0] A_STATUS = BUS_AW'(OFS_STATUS);
    localparam logic [BUS_AW-1:0] A_RD_LEN = BUS_AW'(OFS_RD_LEN);
    localparam logic [BUS_AW-1:0] A_TGT    = BUS_AW'(OFS_TGT);
    localparam logic [BUS_AW-1:0] A_CMD    = BUS_AW'(OFS_CMD);
    localparam logic [BUS_AW-1:0] A_CTL2   = BUS_AW'(OFS_CTL2);
    localparam logic [BUS_AW-1:0] A_WR_LEN = BUS_AW'(OFS_WR_LEN);
    localparam logic [BUS_AW-1:0] A_DIV    = BUS_AW'(OFS_DIV);
    localparam logic [BUS_AW-1:0] A_BUF_LO = BUS_AW'(OFS_BUF);
    localparam logic [BUS_AW-1:0] A_BUF_HI = BUS_AW'(OFS_BUF + 4 * BUF_DEPTH - 1);

    // Software-visible registers
    logic             done_q, crc_q, abort_q, ie_q;
    logic [7:0]       tgt_q, cmd_q;
    logic [LEN_W-1:0] rd_len_q, wr_len_q;
    logic [1:0]       pd_q;
    logic [DIV_W-1:0] div_q;

    logic busy, accept, finish, go;
    logic wr_status, in_buf, host_buf_we;
    logic [IDX_W-1:0] host_idx;
    logic [7:0] host_rdata;
    logic [DIV_W-1:0] div_wr;

    always_comb begin
        wr_status   = bus_wr && (bus_addr == A_STATUS);
        go          = wr_status && bus_wdata[SB_BUSY];
        in_buf      = (bus_addr >= A_BUF_LO) && (bus_addr <= A_BUF_HI) && (bus_addr[1:0] == 2'b00);
        host_idx    = bus_addr[IDX_W+1:2];
        host_buf_we = bus_wr && in_buf && !busy;
        div_wr      = bus_wdata[DIV_W-1:0];
    end

    peci_busy_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .eng_done  (eng_done),
        .busy      (busy),
        .accept    (accept),
        .eng_start (eng_start),
        .finish    (finish)
    );

    peci_bitclk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div_q),
        .tick  (bit_tick)
    );

    peci_byte_buf #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_buf_we),
        .host_idx   (host_idx),
        .host_wdata (bus_wdata),
        .host_rdata (host_rdata),
        .eng_we     (eng_buf_we),
        .eng_idx    (eng_buf_idx),
        .eng_wdata  (eng_buf_wdata),
        .eng_rdata  (eng_buf_rdata)
    );

    // Sticky flags: a set from the engine wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            crc_q   <= 1'b0;
            abort_q <= 1'b0;
            ie_q    <= 1'b0;
        end else begin
            done_q  <= finish | (done_q & ~(wr_status & bus_wdata[SB_DONE]));
            crc_q   <= (finish & eng_crc_err) | (crc_q & ~(wr_status & bus_wdata[SB_CRC]));
            abort_q <= (finish & eng_abort_err) | (abort_q & ~(wr_status & bus_wdata[SB_ABORT]));
            if (wr_status) ie_q <= bus_wdata[SB_IE];
        end
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q    <= '0;
            cmd_q    <= '0;
            rd_len_q <= '0;
            wr_len_q <= '0;
            pd_q     <= '0;
            div_q    <= DIV_W'(DIV_RST);
        end else if (bus_wr) begin
            if (bus_addr == A_TGT)    tgt_q    <= bus_wdata;
            if (bus_addr == A_CMD)    cmd_q    <= bus_wdata;
            if (bus_addr == A_RD_LEN) rd_len_q <= bus_wdata[LEN_W-1:0];
            if (bus_addr == A_WR_LEN) wr_len_q <= bus_wdata[LEN_W-1:0];
            if (bus_addr == A_CTL2 && 32'(bus_wdata[7:6]) <= PD_MAX) pd_q <= bus_wdata[7:6];
            if (bus_addr == A_DIV && 32'(div_wr) >= DIV_MIN && 32'(div_wr) <= DIV_MAX)
                div_q <= div_wr;
        end
    end

    // Engine-side copies latched at START
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_tgt_addr <= '0;
            eng_cmd      <= '0;
            eng_wr_len   <= '0;
            eng_rd_len   <= '0;
            eng_pulldown <= '0;
        end else if (accept) begin
            eng_tgt_addr <= tgt_q;
            eng_cmd      <= cmd_q;
            eng_wr_len   <= wr_len_q;
            eng_rd_len   <= rd_len_q;
            eng_pulldown <= pd_q;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (in_buf) begin
            bus_rdata = host_rdata;
        end else begin
            case (bus_addr)
                A_STATUS: begin
                    bus_rdata[SB_BUSY]  = busy;
                    bus_rdata[SB_DONE]  = done_q;
                    bus_rdata[SB_CRC]   = crc_q;
                    bus_rdata[SB_ABORT] = abort_q;
                    bus_rdata[SB_IE]    = ie_q;
                end
                A_RD_LEN: bus_rdata = 8'(rd_len_q);
                A_TGT:    bus_rdata = tgt_q;
                A_CMD:    bus_rdata = cmd_q;
                A_CTL2:   bus_rdata = {pd_q, 6'b0};
                A_WR_LEN: bus_rdata = 8'(wr_len_q);
                A_DIV:    bus_rdata = 8'(div_q);
                default:  bus_rdata = 8'h00;
            endcase
        end
    end

    assign irq = done_q & ie_q;

    assert_done_on_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && !eng_start) |=> (done_q && !busy));
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && bus_wdata[SB_DONE] && !finish) |=> !done_q);
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(wr_status && bus_wdata[SB_DONE])) |=> done_q);
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(eng_cmd) && $stable(eng_tgt_addr) && $stable(eng_wr_len)));
    assert_div_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(div_q) >= DIV_MIN && 32'(div_q) <= DIV_MAX));
    assert_irq_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_q) |-> !irq);

endmodule

// File: tb/sim_peci_host_regs.sv
`timescale 1ns/1ps
module sim_peci_host_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, eng_start, bit_tick;
    logic       eng_done = 1'b0, eng_crc_err = 1'b0, eng_abort_err = 1'b0;
    logic [7:0] eng_tgt_addr, eng_cmd, eng_buf_rdata;
    logic [6:0] eng_wr_len, eng_rd_len;
    logic [1:0] eng_pulldown;
    logic [5:0] eng_buf_idx = '0;
    logic       eng_buf_we = 1'b0;
    logic [7:0] eng_buf_wdata = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    peci_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .eng_start(eng_start), .eng_done(eng_done), .eng_crc_err(eng_crc_err),
        .eng_abort_err(eng_abort_err), .eng_tgt_addr(eng_tgt_addr), .eng_cmd(eng_cmd),
        .eng_wr_len(eng_wr_len), .eng_rd_len(eng_rd_len), .eng_pulldown(eng_pulldown),
        .eng_buf_idx(eng_buf_idx), .eng_buf_we(eng_buf_we), .eng_buf_wdata(eng_buf_wdata),
        .eng_buf_rdata(eng_buf_rdata), .bit_tick(bit_tick)
    );

    // Bench model of the configuration registers
    logic [7:0] m_tgt = 0, m_cmd = 0, m_rdl = 0, m_wrl = 0, m_ctl2 = 0, m_div = 8'd15;
    logic [7:0] m_buf [64];

    function automatic logic [7:0] exp_len(input logic [7:0] d);
        return d & 8'h7F;
    endfunction
    function automatic logic [7:0] exp_ctl2(input logic [7:0] old, input logic [7:0] d);
        return (d[7:6] <= 2'd2) ? (d & 8'hC0) : old;
    endfunction
    function automatic logic [7:0] exp_div(input logic [7:0] old, input logic [7:0] d);
        return (d[4:0] >= 5'd7) ? {3'b0, d[4:0]} : old;
    endfunction
    function automatic logic [7:0] exp_status(input bit ie, input bit dn, input bit crc, input bit ab);
        return {1'b0, ie, 1'b0, ab, crc, 1'b0, dn, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic engine_done(input bit crc, input bit ab);
        @(negedge clk);
        eng_done = 1'b1; eng_crc_err = crc; eng_abort_err = ab;
        @(negedge clk);
        eng_done = 1'b0; eng_crc_err = 1'b0; eng_abort_err = 1'b0;
    endtask

    task automatic measure(output int gap);
        while (!bit_tick) @(negedge clk);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!bit_tick);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [9:0] a;
        int gap;
        int r;
        for (int i = 0; i < 64; i++) m_buf[i] = 8'h00;
        r = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(10'h000, d); check("R1 status", d, 8'h00);
        rd(10'h02C, d); check("R1 divisor", d, 8'h0F);
        rd(10'h004, d); check("R1 rd_len", d, 8'h00);
        rd(10'h008, d); check("R1 tgt", d, 8'h00);
        rd(10'h00C, d); check("R1 cmd", d, 8'h00);
        rd(10'h010, d); check("R1 ctl2", d, 8'h00);
        rd(10'h01C, d); check("R1 wr_len", d, 8'h00);
        rd(10'h100, d); check("R1 buffer", d, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 eng_start", eng_start, 0);

        // Directed edge values for R7, R8, R9
        wr(10'h004, 8'hFF); m_rdl = exp_len(8'hFF);
        rd(10'h004, d); check("R7 rd_len bit7", d, 8'h7F);
        wr(10'h010, 8'hC0);
        rd(10'h010, d); check("R8 pulldown 3 ignored", d, 8'h00);
        wr(10'h010, 8'hBF); m_ctl2 = 8'h80;
        rd(10'h010, d); check("R8 pulldown 2 low bits", d, 8'h80);
        wr(10'h02C, 8'h06);
        rd(10'h02C, d); check("R9 divisor 6 ignored", d, 8'h0F);
        wr(10'h02C, 8'hE7); m_div = 8'h07;
        rd(10'h02C, d); check("R9 divisor 7 accepted", d, 8'h07);

        // Random register traffic against the model
        for (int i = 0; i < 60; i++) begin
            int sel;
            logic [7:0] v;
            sel = $urandom_range(0, 5);
            v   = 8'($urandom());
            case (sel)
                0: begin wr(10'h008, v); m_tgt = v; rd(10'h008, d); check("R6 tgt readback", d, m_tgt); end
                1: begin wr(10'h00C, v); m_cmd = v; rd(10'h00C, d); check("R6 cmd readback", d, m_cmd); end
                2: begin wr(10'h004, v); m_rdl = exp_len(v); rd(10'h004, d); check("R7 rd_len", d, m_rdl); end
                3: begin wr(10'h01C, v); m_wrl = exp_len(v); rd(10'h01C, d); check("R7 wr_len", d, m_wrl); end
                4: begin wr(10'h010, v); m_ctl2 = exp_ctl2(m_ctl2, v); rd(10'h010, d); check("R8 ctl2", d, m_ctl2); end
                default: begin wr(10'h02C, v); m_div = exp_div(m_div, v); rd(10'h02C, d); check("R9 divisor", d, m_div); end
            endcase
        end

        // R12 buffer placement
        for (int i = 0; i < 12; i++) begin
            int n;
            logic [7:0] v;
            n = (i == 11) ? 63 : $urandom_range(0, 63);
            v = 8'($urandom());
            wr(10'h100 + 10'(4 * n), v); m_buf[n] = v;
        end
        for (int n = 0; n < 64; n += 7) begin
            rd(10'h100 + 10'(4 * n), d); check("R12 buffer readback", d, m_buf[n]);
        end
        rd(10'h1FC, d); check("R12 last entry", d, m_buf[63]);
        wr(10'h101, 8'h5C);
        rd(10'h101, d); check("R12 unaligned reads 0", d, 8'h00);
        rd(10'h100, d); check("R12 unaligned write ignored", d, m_buf[0]);
        @(negedge clk); eng_buf_idx = 6'd63;
        #1 check("R12 engine read port", eng_buf_rdata, m_buf[63]);

        // Directed transaction
        wr(10'h008, 8'h30); m_tgt = 8'h30;
        wr(10'h00C, 8'hA1); m_cmd = 8'hA1;
        wr(10'h01C, 8'h03); m_wrl = 8'h03;
        wr(10'h004, 8'h05); m_rdl = 8'h05;
        wr(10'h000, 8'h01);
        check("R2 eng_start pulse", eng_start, 1);
        check("R2 latched cmd", eng_cmd, 8'hA1);
        check("R2 latched tgt", eng_tgt_addr, 8'h30);
        check("R2 latched pulldown", eng_pulldown, 2'(m_ctl2 >> 6));
        @(negedge clk); check("R2 eng_start one cycle", eng_start, 0);
        rd(10'h000, d); check("R2 busy reads 1", d, 8'h01);
        wr(10'h00C, 8'h5E); m_cmd = 8'h5E;
        wr(10'h01C, 8'h7F); m_wrl = 8'h7F;
        check("R6 eng_cmd held", eng_cmd, 8'hA1);
        check("R6 eng_wr_len held", eng_wr_len, 7'h03);
        rd(10'h00C, d); check("R6 cmd readback while busy", d, 8'h5E);
        wr(10'h000, 8'h01);
        check("R5 no restart pulse", eng_start, 0);
        @(negedge clk); check("R5 no restart pulse later", eng_start, 0);
        wr(10'h104, 8'hEE);
        rd(10'h104, d); check("R12 host write while busy ignored", d, m_buf[1]);
        @(negedge clk);
        eng_buf_idx = 6'd2; eng_buf_wdata = 8'hA5; eng_buf_we = 1'b1;
        @(negedge clk); eng_buf_we = 1'b0; m_buf[2] = 8'hA5;
        engine_done(1'b1, 1'b0);
        rd(10'h000, d); check("R3 done with crc", d, exp_status(0, 1, 1, 0));
        check("R11 irq disabled", irq, 0);
        rd(10'h108, d); check("R12 engine write visible", d, 8'hA5);
        wr(10'h000, 8'h40);
        rd(10'h000, d); check("R4 write 0 keeps flags", d, exp_status(1, 1, 1, 0));
        check("R11 irq on", irq, 1);
        wr(10'h000, 8'h48);
        rd(10'h000, d); check("R4 clear crc", d, exp_status(1, 1, 0, 0));
        check("R11 irq stays", irq, 1);
        wr(10'h000, 8'h42);
        rd(10'h000, d); check("R4 clear done", d, exp_status(1, 0, 0, 0));
        check("R11 irq off", irq, 0);

        // Random transactions
        for (int i = 0; i < 24; i++) begin
            bit c, ab;
            logic [7:0] v;
            c = 1'($urandom()); ab = 1'($urandom()); v = 8'($urandom());
            wr(10'h00C, v);
            wr(10'h000, 8'h41);
            check("R2 start pulse", eng_start, 1);
            check("R6 latched cmd", eng_cmd, v);
            repeat ($urandom_range(0, 4)) @(negedge clk);
            engine_done(c, ab);
            rd(10'h000, d); check("R3 status after finish", d, exp_status(1, 1, c, ab));
            check("R11 irq after finish", irq, 1);
            wr(10'h000, 8'h5A);
            rd(10'h000, d); check("R4 clear all", d, exp_status(1, 0, 0, 0));
        end

        // R10 bit tick spacing
        wr(10'h02C, 8'h07);
        measure(gap); measure(gap); check("R10 tick N=7", gap, 32);
        wr(10'h02C, 8'h1F);
        measure(gap); measure(gap); check("R10 tick N=31", gap, 128);
        wr(10'h02C, 8'h0F);
        measure(gap); measure(gap); check("R10 tick N=15", gap, 64);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule